// File: doc/BRIEF.md
# Sync-Origin Raster Timing Generator

This block produces the horizontal and vertical raster timing for one display pipe. A pixel counter and a line counter both start at zero on the leading edge of sync. Because of this, the end of blanking lies at a lower count than the start of blanking on each axis. From the programmed totals, blank window edges, sync widths, border sizes and sync polarities, the block derives the following signals:

- hsync and vsync
- hblank and vblank
- data enable
- a three-way pixel selector, which picks between incoming active data, an overscan (border) colour and a blank colour
- a one-cycle start-of-line request marker, placed a few lines ahead of the first visible line

The block also exposes its current counts, an odd-field flag for interlaced output and a frame counter. Software writes the timing inputs at any time. The block copies them into its working set only at the start of vertical blank, or at any time while the master enable is off, so a change never tears a frame.

Top module: `crtc_timing_gen`

## Requirements
- R1: The pixel counter runs from 0 to the programmed horizontal total (line length minus one) and then returns to 0. The line counter steps once per line wrap and returns to 0 after its last line, which is the vertical total (frame height minus one).
- R2: On each axis, the sync pulse is active for counts 0 up to sync end minus one. This makes the pulse width equal to the programmed sync end value.
- R3: A sync polarity bit of 0 gives an active-high pulse, and a bit of 1 gives an active-low pulse. With a bit of 1, the idle level is 1.
- R4: hblank is 0 only when the pixel count is at or above blank end and below blank start. vblank follows the same rule using the line count, and vblank also serves as the vertical-blank status flag. de is 1 exactly when neither blank is asserted.
- R5: pix_sel is encoded as 0 = active, 1 = overscan, 2 = blank. It is 2 outside de. Inside de it is 1 on border pixels, which are the first left-border pixels after blank end, the last right-border pixels before blank start, and the same on the vertical axis using the top and bottom borders. All other pixels give 0. pix_out carries the selected colour. Each colour is packed as blue/Cb in the low PIX_W bits, green/Y in the middle and red/Cr in the top.
- R6: While blank_data_en is 1, every pixel inside de selects the blank colour (pix_sel = 2). Clearing the bit restores normal selection.
- R7: The frame counter increments by one as the line counter wraps from its last line to 0.
- R8: start_req pulses for one cycle at pixel 0 of a request line, which sits P lines before blank end and wraps around the frame when needed. With the advanced mode on, P is 3 if (sync end + total + 1 − blank start) ≤ 3, and P is 4 otherwise. With the advanced mode off, P is 2.
- R9: While master_en is 0, both counters are held at 0 and the field is even. The frame counter holds its value, both syncs sit at their idle level, both blanks are 1, de is 0 and pix_sel is 2. After master_en rises, counting resumes from count 0.
- R10: With interlace on, the field flag toggles at each frame wrap. The odd field has one extra line. On the odd field, vsync is shifted by half a line: it starts at pixel (total+1)/2 of line 0 and ends at that pixel of line sync end. The frame counter increments only when the odd field wraps.
- R11: The timing inputs take effect only at the clock edge where the line counter enters the blank-start line at pixel 0, or at any edge while master_en is 0. Until then, the previous values keep governing all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Counter run enable |
| blank_data_en | input | 1 | Force blank colour inside the visible window |
| cfg_h_total | input | TG_CW | Line length minus one |
| cfg_h_blank_end | input | TG_CW | First visible pixel count |
| cfg_h_blank_start | input | TG_CW | First blanked pixel after the visible window |
| cfg_h_sync_end | input | TG_CW | Horizontal sync width |
| cfg_h_border_l | input | TG_CW | Left border width |
| cfg_h_border_r | input | TG_CW | Right border width |
| cfg_v_total | input | TG_CW | Frame height minus one |
| cfg_v_blank_end | input | TG_CW | First visible line |
| cfg_v_blank_start | input | TG_CW | First blanked line after the visible window |
| cfg_v_sync_end | input | TG_CW | Vertical sync width in lines |
| cfg_v_border_t | input | TG_CW | Top border height |
| cfg_v_border_b | input | TG_CW | Bottom border height |
| cfg_hsync_pol | input | 1 | 1 = active-low hsync |
| cfg_vsync_pol | input | 1 | 1 = active-low vsync |
| cfg_interlace | input | 1 | Interlaced field sequencing |
| cfg_adv_req | input | 1 | Advanced start-line request placement |
| active_pix | input | 3*PIX_W | Incoming active pixel |
| overscan_color | input | 3*PIX_W | Border colour |
| blank_color | input | 3*PIX_W | Blank colour |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank / status flag |
| de | output | 1 | Data enable |
| pix_sel | output | 2 | Pixel source select |
| pix_out | output | 3*PIX_W | Selected pixel |
| h_count | output | TG_CW | Current pixel count |
| v_count | output | TG_CW | Current line count |
| field_odd | output | 1 | Odd field flag |
| frame_count | output | FRM_W | Frame counter |
| start_req | output | 1 | Start-of-line request marker |

## Verification
The bench keeps its own model of the working timing set and changes the inputs mid-frame. A design that adopts new values at once, rather than at the vertical blank start, shows a shortened sync or a shifted window within the same frame. It also uses random timings whose blank end lies fewer lines from the origin than the request distance. This exposes a request line that fails to wrap, and the near/far placement choice at the boundary value 3. Interlaced fields test the half-line vsync and the extra odd line, where an off-by-one gives a vsync edge at the wrong pixel or a frame counter that steps every field. The bench also toggles the master enable in the middle of a line, which catches counters that do not hold at the origin or outputs that are not left idle.

// File: rtl/tg_pkg.sv
package tg_pkg;
  parameter int TG_CW = 12;
  typedef logic [TG_CW-1:0] cnt_t;

  typedef enum logic [1:0] {
    PSEL_ACTIVE   = 2'd0,
    PSEL_OVERSCAN = 2'd1,
    PSEL_BLANK    = 2'd2
  } psel_e;

  typedef struct packed {
    cnt_t h_total;
    cnt_t h_blank_end;
    cnt_t h_blank_start;
    cnt_t h_sync_end;
    cnt_t h_bord_l;
    cnt_t h_bord_r;
    cnt_t v_total;
    cnt_t v_blank_end;
    cnt_t v_blank_start;
    cnt_t v_sync_end;
    cnt_t v_bord_t;
    cnt_t v_bord_b;
    logic h_pol;
    logic v_pol;
    logic ilace;
    logic adv_req;
  } tg_cfg_t;

  localparam int REQ_POS_NEAR   = 3;
  localparam int REQ_POS_FAR    = 4;
  localparam int REQ_POS_LEGACY = 2;
  localparam int REQ_NEAR_LIMIT = 3;
endpackage

// File: rtl/tg_shadow.sv
module tg_shadow
  import tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  tg_cfg_t cfg_in,
  output tg_cfg_t cfg_act
);
  tg_cfg_t act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (load) act_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign cfg_act = act_q;

  AST_HOLD_BETWEEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_act)); // R11
endmodule

// File: rtl/tg_counter.sv
module tg_counter
  import tg_pkg::*;
#(
  parameter int FRM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cnt_t             h_total,
  input  cnt_t             v_total,
  input  cnt_t             v_blank_start,
  input  logic             ilace,
  output cnt_t             h_cnt,
  output cnt_t             v_cnt,
  output logic             field,
  output logic [FRM_W-1:0] frame_cnt,
  output logic             load_pt
);
  cnt_t             h_q, h_d, v_q, v_d, v_last;
  logic             f_q, f_d, h_wrap, v_wrap;
  logic [FRM_W-1:0] frm_q, frm_d;

  always_comb begin
    h_wrap = (h_q >= h_total);
    v_last = v_total + cnt_t'(ilace && f_q);
    v_wrap = (v_q >= v_last);
    h_d    = h_q;
    v_d    = v_q;
    f_d    = f_q;
    frm_d  = frm_q;
    if (!en) begin
      h_d = '0;
      v_d = '0;
      f_d = 1'b0;
    end else begin
      h_d = h_wrap ? '0 : h_q + cnt_t'(1);
      if (h_wrap) begin
        v_d = v_wrap ? '0 : v_q + cnt_t'(1);
        if (v_wrap) begin
          f_d = ilace ? ~f_q : 1'b0;
          if (!ilace || f_q) frm_d = frm_q + {{(FRM_W-1){1'b0}}, 1'b1};
        end
      end
    end
    load_pt = !en || (h_wrap && (v_d == v_blank_start));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      v_q   <= '0;
      f_q   <= 1'b0;
      frm_q <= '0;
    end else begin
      h_q   <= h_d;
      v_q   <= v_d;
      f_q   <= f_d;
      frm_q <= frm_d;
    end
  end

  assign h_cnt     = h_q;
  assign v_cnt     = v_q;
  assign field     = f_q;
  assign frame_cnt = frm_q;

  AST_H_RETURNS_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt >= h_total) |=> (h_cnt == '0)); // R1
  AST_H_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt < h_total) |=> (h_cnt == $past(h_cnt) + cnt_t'(1))); // R1
  AST_IDLE_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (h_cnt == '0 && v_cnt == '0 && !field)); // R9
  AST_FRAME_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_cnt == $past(frame_cnt) ||
              frame_cnt == $past(frame_cnt) + {{(FRM_W-1){1'b0}}, 1'b1})); // R7
endmodule

// File: rtl/tg_decode.sv
module tg_decode
  import tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    blank_data_en,
  input  tg_cfg_t cfg,
  input  cnt_t    h_cnt,
  input  cnt_t    v_cnt,
  input  logic    field,
  output logic    hsync,
  output logic    vsync,
  output logic    hblank,
  output logic    vblank,
  output logic    de,
  output psel_e   psel,
  output logic    start_req
);
  logic           h_vis, v_vis, h_addr, v_addr, hs_on, vs_on, near;
  logic [TG_CW:0] ht_p1, vt_p1, lead_sum;
  cnt_t           half, req_pos, req_line;

  always_comb begin
    h_vis  = (h_cnt >= cfg.h_blank_end) && (h_cnt < cfg.h_blank_start);
    v_vis  = (v_cnt >= cfg.v_blank_end) && (v_cnt < cfg.v_blank_start);
    h_addr = (h_cnt >= cfg.h_blank_end + cfg.h_bord_l) &&
             (h_cnt < cfg.h_blank_start - cfg.h_bord_r);
    v_addr = (v_cnt >= cfg.v_blank_end + cfg.v_bord_t) &&
             (v_cnt < cfg.v_blank_start - cfg.v_bord_b);

    ht_p1 = {1'b0, cfg.h_total} + {{TG_CW{1'b0}}, 1'b1};
    half  = cnt_t'(ht_p1 >> 1);
    hs_on = en && (h_cnt < cfg.h_sync_end);
    if (cfg.ilace && field)
      vs_on = en && ((v_cnt > '0) || (h_cnt >= half)) &&
              ((v_cnt < cfg.v_sync_end) ||
               ((v_cnt == cfg.v_sync_end) && (h_cnt < half)));
    else
      vs_on = en && (v_cnt < cfg.v_sync_end);

    hsync  = hs_on ^ cfg.h_pol;
    vsync  = vs_on ^ cfg.v_pol;
    hblank = !en || !h_vis;
    vblank = !en || !v_vis;
    de     = en && h_vis && v_vis;

    if (!de || blank_data_en)   psel = PSEL_BLANK;
    else if (!(h_addr && v_addr)) psel = PSEL_OVERSCAN;
    else                        psel = PSEL_ACTIVE;

    vt_p1    = {1'b0, cfg.v_total} + {{TG_CW{1'b0}}, 1'b1};
    lead_sum = vt_p1 - {1'b0, cfg.v_blank_start} + {1'b0, cfg.v_sync_end};
    near     = (lead_sum <= (TG_CW+1)'(REQ_NEAR_LIMIT));
    if (!cfg.adv_req) req_pos = cnt_t'(REQ_POS_LEGACY);
    else if (near)    req_pos = cnt_t'(REQ_POS_NEAR);
    else              req_pos = cnt_t'(REQ_POS_FAR);
    if (cfg.v_blank_end >= req_pos)
      req_line = cfg.v_blank_end - req_pos;
    else
      req_line = vt_p1[TG_CW-1:0] + cfg.v_blank_end - req_pos;
    start_req = en && (v_cnt == req_line) && (h_cnt == '0);
  end

  AST_DE_OUTSIDE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hblank && !vblank)); // R4
  AST_SYNC_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (hsync == cfg.h_pol && vsync == cfg.v_pol && psel == PSEL_BLANK)); // R9
  AST_REQ_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (h_cnt == '0)); // R8
  AST_FORCED_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    blank_data_en |-> (psel == PSEL_BLANK)); // R6
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import tg_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int FRM_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_en,
  input  logic               blank_data_en,
  input  logic [TG_CW-1:0]   cfg_h_total,
  input  logic [TG_CW-1:0]   cfg_h_blank_end,
  input  logic [TG_CW-1:0]   cfg_h_blank_start,
  input  logic [TG_CW-1:0]   cfg_h_sync_end,
  input  logic [TG_CW-1:0]   cfg_h_border_l,
  input  logic [TG_CW-1:0]   cfg_h_border_r,
  input  logic [TG_CW-1:0]   cfg_v_total,
  input  logic [TG_CW-1:0]   cfg_v_blank_end,
  input  logic [TG_CW-1:0]   cfg_v_blank_start,
  input  logic [TG_CW-1:0]   cfg_v_sync_end,
  input  logic [TG_CW-1:0]   cfg_v_border_t,
  input  logic [TG_CW-1:0]   cfg_v_border_b,
  input  logic               cfg_hsync_pol,
  input  logic               cfg_vsync_pol,
  input  logic               cfg_interlace,
  input  logic               cfg_adv_req,
  input  logic [3*PIX_W-1:0] active_pix,
  input  logic [3*PIX_W-1:0] overscan_color,
  input  logic [3*PIX_W-1:0] blank_color,
  output logic               hsync,
  output logic               vsync,
  output logic               hblank,
  output logic               vblank,
  output logic               de,
  output logic [1:0]         pix_sel,
  output logic [3*PIX_W-1:0] pix_out,
  output logic [TG_CW-1:0]   h_count,
  output logic [TG_CW-1:0]   v_count,
  output logic               field_odd,
  output logic [FRM_W-1:0]   frame_count,
  output logic               start_req
);
  localparam int NCOMP = 3;

  tg_cfg_t cfg_in, cfg_act;
  logic    load_pt;
  psel_e   psel;

  always_comb begin
    cfg_in.h_total       = cfg_h_total;
    cfg_in.h_blank_end   = cfg_h_blank_end;
    cfg_in.h_blank_start = cfg_h_blank_start;
    cfg_in.h_sync_end    = cfg_h_sync_end;
    cfg_in.h_bord_l      = cfg_h_border_l;
    cfg_in.h_bord_r      = cfg_h_border_r;
    cfg_in.v_total       = cfg_v_total;
    cfg_in.v_blank_end   = cfg_v_blank_end;
    cfg_in.v_blank_start = cfg_v_blank_start;
    cfg_in.v_sync_end    = cfg_v_sync_end;
    cfg_in.v_bord_t      = cfg_v_border_t;
    cfg_in.v_bord_b      = cfg_v_border_b;
    cfg_in.h_pol         = cfg_hsync_pol;
    cfg_in.v_pol         = cfg_vsync_pol;
    cfg_in.ilace         = cfg_interlace;
    cfg_in.adv_req       = cfg_adv_req;
  end

  tg_shadow u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_pt),
    .cfg_in  (cfg_in),
    .cfg_act (cfg_act)
  );

  tg_counter #(.FRM_W(FRM_W)) u_counter (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (master_en),
    .h_total       (cfg_act.h_total),
    .v_total       (cfg_act.v_total),
    .v_blank_start (cfg_act.v_blank_start),
    .ilace         (cfg_act.ilace),
    .h_cnt         (h_count),
    .v_cnt         (v_count),
    .field         (field_odd),
    .frame_cnt     (frame_count),
    .load_pt       (load_pt)
  );

  tg_decode u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (master_en),
    .blank_data_en (blank_data_en),
    .cfg           (cfg_act),
    .h_cnt         (h_count),
    .v_cnt         (v_count),
    .field         (field_odd),
    .hsync         (hsync),
    .vsync         (vsync),
    .hblank        (hblank),
    .vblank        (vblank),
    .de            (de),
    .psel          (psel),
    .start_req     (start_req)
  );

  assign pix_sel = psel;

  for (genvar k = 0; k < NCOMP; k++) begin : g_comp
    assign pix_out[k*PIX_W +: PIX_W] =
      (psel == PSEL_ACTIVE)   ? active_pix[k*PIX_W +: PIX_W] :
      (psel == PSEL_OVERSCAN) ? overscan_color[k*PIX_W +: PIX_W] :
                                blank_color[k*PIX_W +: PIX_W];
  end
endmodule

// File: tb/crtc_timing_gen_test.sv
module crtc_timing_gen_test;
  import tg_pkg::*;
  localparam int PIX_W = 10;
  localparam int FRM_W = 16;
  localparam int PW3   = 3*PIX_W;

  logic clk = 1'b0;
  logic rst_n, master_en, blank_data_en;
  tg_cfg_t cin;
  logic [PW3-1:0] active_pix, overscan_color, blank_color;
  logic hsync, vsync, hblank, vblank, de, field_odd, start_req;
  logic [1:0] pix_sel;
  logic [PW3-1:0] pix_out;
  logic [TG_CW-1:0] h_count, v_count;
  logic [FRM_W-1:0] frame_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  tg_cfg_t ma;
  int mh, mv, mf, mfrm;

  always #5 clk = ~clk;

  crtc_timing_gen #(.PIX_W(PIX_W), .FRM_W(FRM_W)) uut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .blank_data_en(blank_data_en),
    .cfg_h_total(cin.h_total), .cfg_h_blank_end(cin.h_blank_end),
    .cfg_h_blank_start(cin.h_blank_start), .cfg_h_sync_end(cin.h_sync_end),
    .cfg_h_border_l(cin.h_bord_l), .cfg_h_border_r(cin.h_bord_r),
    .cfg_v_total(cin.v_total), .cfg_v_blank_end(cin.v_blank_end),
    .cfg_v_blank_start(cin.v_blank_start), .cfg_v_sync_end(cin.v_sync_end),
    .cfg_v_border_t(cin.v_bord_t), .cfg_v_border_b(cin.v_bord_b),
    .cfg_hsync_pol(cin.h_pol), .cfg_vsync_pol(cin.v_pol),
    .cfg_interlace(cin.ilace), .cfg_adv_req(cin.adv_req),
    .active_pix(active_pix), .overscan_color(overscan_color), .blank_color(blank_color),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank), .de(de),
    .pix_sel(pix_sel), .pix_out(pix_out), .h_count(h_count), .v_count(v_count),
    .field_odd(field_odd), .frame_count(frame_count), .start_req(start_req)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at h=%0d v=%0d", tag, what, act, exp, mh, mv);
    end
  endtask

  function automatic tg_cfg_t mk_cfg(int ht, int hbe, int hbs, int hse, int bl, int br,
                                     int vt, int vbe, int vbs, int vse, int bt, int bb,
                                     bit hp, bit vp, bit il, bit adv);
    tg_cfg_t c;
    c.h_total = cnt_t'(ht); c.h_blank_end = cnt_t'(hbe); c.h_blank_start = cnt_t'(hbs);
    c.h_sync_end = cnt_t'(hse); c.h_bord_l = cnt_t'(bl); c.h_bord_r = cnt_t'(br);
    c.v_total = cnt_t'(vt); c.v_blank_end = cnt_t'(vbe); c.v_blank_start = cnt_t'(vbs);
    c.v_sync_end = cnt_t'(vse); c.v_bord_t = cnt_t'(bt); c.v_bord_b = cnt_t'(bb);
    c.h_pol = hp; c.v_pol = vp; c.ilace = il; c.adv_req = adv;
    return c;
  endfunction

  function automatic tg_cfg_t rand_cfg();
    int hse, hbe, bl, br, hbs, ht, vse, vbe, bt, bb, vbs, vt;
    hse = 1 + $urandom % 4;  hbe = hse + 1 + $urandom % 3;
    bl = $urandom % 3;  br = $urandom % 3;
    hbs = hbe + bl + br + 4 + $urandom % 6;  ht = hbs + 1 + $urandom % 4;
    vse = 1 + $urandom % 3;  vbe = vse + 1 + $urandom % 2;
    bt = $urandom % 2;  bb = $urandom % 2;
    vbs = vbe + bt + bb + 3 + $urandom % 4;  vt = vbs + $urandom % 3;
    return mk_cfg(ht, hbe, hbs, hse, bl, br, vt, vbe, vbs, vse, bt, bb,
                  $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
  endfunction

  function automatic int req_line_of(tg_cfg_t c);
    int pos, lead;
    lead = int'(c.v_sync_end) + int'(c.v_total) + 1 - int'(c.v_blank_start);
    if (!c.adv_req) pos = 2;
    else pos = (lead <= 3) ? 3 : 4;
    if (int'(c.v_blank_end) >= pos) return int'(c.v_blank_end) - pos;
    return int'(c.v_total) + 1 + int'(c.v_blank_end) - pos;
  endfunction

  task automatic do_check();
    bit en, hd, vd, ha, va, hs, vs, ede, ereq;
    int half, esel;
    logic [PW3-1:0] epix;
    string tg;
    en = master_en;
    hd = mh >= int'(ma.h_blank_end) && mh < int'(ma.h_blank_start);
    vd = mv >= int'(ma.v_blank_end) && mv < int'(ma.v_blank_start);
    ha = mh >= int'(ma.h_blank_end) + int'(ma.h_bord_l) &&
         mh < int'(ma.h_blank_start) - int'(ma.h_bord_r);
    va = mv >= int'(ma.v_blank_end) + int'(ma.v_bord_t) &&
         mv < int'(ma.v_blank_start) - int'(ma.v_bord_b);
    hs = en && mh < int'(ma.h_sync_end);
    half = (int'(ma.h_total) + 1) / 2;
    if (ma.ilace && mf != 0)
      vs = en && (mv > 0 || mh >= half) &&
           (mv < int'(ma.v_sync_end) || (mv == int'(ma.v_sync_end) && mh < half));
    else
      vs = en && mv < int'(ma.v_sync_end);
    ede = en && hd && vd;
    if (!ede || blank_data_en) esel = 2;
    else if (!(ha && va)) esel = 1;
    else esel = 0;
    epix = (esel == 0) ? active_pix : (esel == 1) ? overscan_color : blank_color;
    ereq = en && mv == req_line_of(ma) && mh == 0;

    tg = !en ? "R9" : (cin != ma) ? "R11" : "R1";
    check(h_count == cnt_t'(mh), tg, "h_count", h_count, mh);
    check(v_count == cnt_t'(mv), tg, "v_count", v_count, mv);
    check(hsync == (hs ^ ma.h_pol), ma.h_pol ? "R3" : "R2", "hsync", hsync, hs ^ ma.h_pol);
    check(vsync == (vs ^ ma.v_pol), (ma.ilace && mf != 0) ? "R10" : ma.v_pol ? "R3" : "R2",
          "vsync", vsync, vs ^ ma.v_pol);
    check(hblank == (!en || !hd), "R4", "hblank", hblank, !en || !hd);
    check(vblank == (!en || !vd), "R4", "vblank", vblank, !en || !vd);
    check(de == ede, "R4", "de", de, ede);
    check(pix_sel == 2'(esel), blank_data_en ? "R6" : "R5", "pix_sel", pix_sel, esel);
    check(pix_out == epix, "R5", "pix_out", pix_out, epix);
    check(frame_count == FRM_W'(mfrm), ma.ilace ? "R10" : "R7", "frame_count", frame_count, mfrm);
    check(field_odd == (mf != 0), "R10", "field_odd", field_odd, mf);
    check(start_req == ereq, "R8", "start_req", start_req, ereq);
  endtask

  task automatic model_step();
    bit hw, vw;
    int vl, vn;
    hw = mh >= int'(ma.h_total);
    vl = int'(ma.v_total) + ((ma.ilace && mf != 0) ? 1 : 0);
    vw = mv >= vl;
    vn = mv;
    if (!master_en) begin
      mh = 0; mv = 0; mf = 0; vn = 0;
    end else begin
      if (hw) begin
        vn = vw ? 0 : mv + 1;
        if (vw) begin
          if (!ma.ilace || mf != 0) mfrm = (mfrm + 1) % (1 << FRM_W);
          mf = ma.ilace ? (mf ^ 1) : 0;
        end
      end
      mh = hw ? 0 : mh + 1;
      mv = vn;
    end
    if (!master_en || (hw && vn == int'(ma.v_blank_start))) ma = cin;
  endtask

  task automatic tick(input int bde_pct);
    active_pix    = PW3'({$urandom, $urandom});
    blank_data_en = (($urandom % 100) < bde_pct);
    model_step();
    @(negedge clk);
    do_check();
  endtask

  task automatic run(input int n, input int bde_pct);
    for (int i = 0; i < n; i++) tick(bde_pct);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    overscan_color = {10'h155, 10'h0AA, 10'h3C3};
    blank_color    = {10'h040, 10'h200, 10'h040};
    active_pix = '0;
    blank_data_en = 1'b0;
    master_en = 1'b0;
    // cfg A: lead = 2+12-10 = 4 -> far position 4, request line 5-4 = 1 (R8)
    cin = mk_cfg(19, 6, 18, 3, 1, 1, 11, 5, 10, 2, 1, 1, 0, 0, 0, 1);
    rst_n = 1'b0;
    ma = '0; mh = 0; mv = 0; mf = 0; mfrm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state with master enable off (R9)
    check(h_count == '0 && v_count == '0 && frame_count == '0, "R9", "reset counts",
          {h_count, v_count}, 0);
    check(de == 1'b0 && pix_sel == 2'd2 && hblank && vblank, "R9", "reset idle",
          {de, pix_sel}, 2);
    do_check();
    run(4, 0);
    master_en = 1'b1;
    run(3 * 240, 0);
    run(2 * 240, 20);                          // R6 forced blank mixed in
    // cfg B mid-frame: lead = 1+2 = 3 -> near position 3 (R8), active-low syncs (R11)
    repeat (37) tick(0);
    cin = mk_cfg(23, 7, 21, 2, 2, 1, 11, 5, 10, 1, 1, 1, 1, 1, 0, 1);
    run(3 * 288, 0);
    cin.adv_req = 1'b0;                        // legacy position 2 (R8)
    run(2 * 288 + 50, 0);
    master_en = 1'b0;                          // hold mid-line (R9)
    run(25, 0);
    master_en = 1'b1;
    run(300, 0);
    cin.ilace = 1'b1;                          // interlaced fields (R10)
    run(5 * 300, 10);
    for (int k = 0; k < 30; k++) begin
      cin = rand_cfg();
      if ($urandom % 4 == 0) begin
        master_en = 1'b0;
        run(1 + $urandom % 5, 0);
        master_en = 1'b1;
      end
      run(1500 + $urandom % 500, 5);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule